// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable model of a single-port synchronous static RAM with a 32-bit word made of four byte lanes and a parameterized depth. Every control, address and data input is captured on the rising clock edge. An access sequence (a burst) opens when either of two address strobes is seen while the three chip-select inputs are in their select state. After that, an internal 2-bit counter walks the low address bits through up to four words. The counter can run in linear or in interleaved order. Holding the advance input inactive repeats the current address, which is how a bus master inserts wait states.

The two strobes differ in what they start. The processor strobe always starts with a read. The controller strobe starts a write when the write condition holds and a read otherwise. Writes can cover the whole word through a global write input, or chosen lanes through a byte-write enable together with per-lane enables. Read data leaves through an output register, so the word appears one edge after its address was taken. The output drive is gated without a clock by an active-low output enable. The shared bus is split into separate data-in, data-out and drive-enable ports.

A sleep input powers the block down. Once sleep falls, the block ignores three more edges before it accepts accesses again. The stored contents are kept throughout.

Top module: `burst_sram`

## Requirements
- R1: The block is selected when `cs1_n_i`=0, `cs2_i`=1 and `cs3_n_i`=0. A strobe seen while it is not selected closes any open burst. `data_oe_o` then stays 0 until a new burst starts.
- R2: A start by `proc_strobe_n_i`=0 is always a read, whatever the write inputs are. Write inputs asserted on a following edge with `advance_n_i`=1 write the burst's current address.
- R3: A start by `ctrl_strobe_n_i`=0 without the processor strobe writes when the write condition holds and reads otherwise.
- R4: The write condition is `global_wr_n_i`=0, or `byte_wr_en_n_i`=0 with at least one `lane_n_i` bit at 0. Global write stores all four lanes. Otherwise lane k (bits [8k+7:8k]) is stored only when `lane_n_i[k]`=0 and `byte_wr_en_n_i`=0.
- R5: Read data for an address taken at edge k appears on `data_o` after edge k+1. `data_oe_o` is 1 then if `out_en_n_i`=0.
- R6: `out_en_n_i`=1 forces `data_oe_o` to 0 without waiting for a clock and leaves `data_o` unchanged.
- R7: With `advance_n_i`=0 the word address steps through its low two bits. The step is base+n modulo 4 when `linear_i`=1 and base XOR n when `linear_i`=0. The upper address bits stay fixed.
- R8: With `advance_n_i`=1 and no strobe, an open burst repeats its current address.
- R9: While `sleep_i`=1, and on the first three edges after it falls, all accesses are ignored. Any burst is closed and `data_oe_o` drops to 0. Memory contents are kept.
- R10: The processor strobe is ignored while `cs1_n_i`=1, and an open burst continues.
- R11: After reset `data_oe_o` is 0, no burst is open and the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address taken at a burst start |
| cs1_n_i | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_n_i | input | 1 | Chip select 3, active low |
| proc_strobe_n_i | input | 1 | Processor address strobe, active low; starts a read burst |
| ctrl_strobe_n_i | input | 1 | Controller address strobe, active low; starts a read or write burst |
| advance_n_i | input | 1 | Burst advance, active low; high holds the current address |
| global_wr_n_i | input | 1 | Global write, active low; all lanes |
| byte_wr_en_n_i | input | 1 | Byte-write enable, active low; qualifies lane_n_i |
| lane_n_i | input | 4 | Per-lane write enables, active low, bit k for bits [8k+7:8k] |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep_i | input | 1 | Power-down request, active high |
| out_en_n_i | input | 1 | Output enable, active low, unclocked |
| data_i | input | 32 | Write data, taken with the write controls |
| data_o | output | 32 | Registered read data |
| data_oe_o | output | 1 | Drive enable for data_o |

## Verification
The main function is tried with four kinds of burst. A linear write burst starts at an aligned base, and a linear read burst starts from a mid-group address, so the modulo-4 wrap shows. An interleaved read burst starts from an odd base, which separates the XOR order from the linear one. Suspend cycles tell a held address from an advancing one. Lane patterns and strobe choices are then crossed: global write, two-lane and single-lane byte writes, byte enables with the byte-write enable inactive, and a processor-strobe start with writes asserted. Read-backs show which lanes and which addresses changed. The sleep sequence places writes on the last ignored edge and on the first accepted edge, which pins down the length of the wake-up window.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    // One access handed from the control stage to the storage stage.
    typedef struct packed {
        logic              valid;
        logic              write;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] data;
    } acc_t;

    // Lanes to store: global write wins, else byte enables gated by byte-write enable.
    function automatic logic [LANES-1:0] lane_mask(input logic gw_n,
                                                   input logic bwe_n,
                                                   input logic [LANES-1:0] lane_n);
        logic [LANES-1:0] m;
        if (!gw_n)       m = '1;
        else if (!bwe_n) m = ~lane_n;
        else             m = '0;
        return m;
    endfunction

    // Low address bits of burst step n from a base, in either order.
    function automatic logic [BURST_W-1:0] burst_offset(input logic [BURST_W-1:0] base,
                                                        input logic [BURST_W-1:0] step,
                                                        input logic linear);
        return linear ? (base + step) : (base ^ step);
    endfunction

endpackage

// File: rtl/burst_sram_wake.sv
module burst_sram_wake #(
    parameter int WAKE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_i,
    output logic awake_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] WAKE_LOAD = CW'(WAKE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (sleep_i)       cnt_q <= WAKE_LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign awake_o = !sleep_i && (cnt_q == '0);

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              awake_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              cs3_n_i,
    input  logic              proc_strobe_n_i,
    input  logic              ctrl_strobe_n_i,
    input  logic              advance_n_i,
    input  logic              global_wr_n_i,
    input  logic              byte_wr_en_n_i,
    input  logic [LANES-1:0]  lane_n_i,
    input  logic              linear_i,
    input  logic [DATA_W-1:0] data_i,
    output acc_t              acc_o,
    output logic [ADDR_W-1:0] acc_addr_o
);
    logic               active_q, active_d;
    logic [ADDR_W-1:0]  base_q, base_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    acc_t               acc_q, acc_d;
    logic [ADDR_W-1:0]  addr_q, addr_d;

    logic             selected, proc_start, ctrl_start;
    logic [LANES-1:0] wmask;
    logic             wr_cond;

    always_comb begin
        selected   = !cs1_n_i && cs2_i && !cs3_n_i;
        proc_start = !proc_strobe_n_i && !cs1_n_i;
        ctrl_start = !ctrl_strobe_n_i;
        wmask      = lane_mask(global_wr_n_i, byte_wr_en_n_i, lane_n_i);
        wr_cond    = |wmask;

        active_d = active_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        addr_d   = addr_q;
        acc_d    = '0;

        if (!awake_i) begin
            active_d = 1'b0;
        end else if (proc_start || ctrl_start) begin
            if (!selected) begin
                active_d = 1'b0;
            end else begin
                active_d     = 1'b1;
                base_d       = addr_i;
                cnt_d        = '0;
                addr_d       = addr_i;
                acc_d.valid  = 1'b1;
                acc_d.write  = !proc_start && wr_cond;
                acc_d.mask   = acc_d.write ? wmask : '0;
                acc_d.data   = data_i;
            end
        end else if (active_q) begin
            if (!advance_n_i) cnt_d = cnt_q + 2'd1;
            addr_d      = {base_q[ADDR_W-1:BURST_W],
                           burst_offset(base_q[BURST_W-1:0], cnt_d, linear_i)};
            acc_d.valid = 1'b1;
            acc_d.write = wr_cond;
            acc_d.mask  = wmask;
            acc_d.data  = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
            addr_q   <= '0;
            acc_q    <= '0;
        end else begin
            active_q <= active_d;
            base_q   <= base_d;
            cnt_q    <= cnt_d;
            addr_q   <= addr_d;
            acc_q    <= acc_d;
        end
    end

    assign acc_o      = acc_q;
    assign acc_addr_o = addr_q;

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              rd_valid_q;

    // Self-timed write: lanes of the registered access are stored on the next edge.
    always_ff @(posedge clk) begin
        if (acc_i.valid && acc_i.write) begin
            for (int k = 0; k < LANES; k++) begin
                if (acc_i.mask[k])
                    mem[acc_addr_i][k*LANE_W +: LANE_W] <= acc_i.data[k*LANE_W +: LANE_W];
            end
        end
    end

    // Output register: doubles as the delayed select that gates the drive.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q       <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= acc_i.valid && !acc_i.write;
            if (acc_i.valid && !acc_i.write) rd_q <= mem[acc_addr_i];
        end
    end

    assign rd_data_o  = rd_q;
    assign rd_valid_o = rd_valid_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int WAKE_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              cs3_n_i,
    input  logic              proc_strobe_n_i,
    input  logic              ctrl_strobe_n_i,
    input  logic              advance_n_i,
    input  logic              global_wr_n_i,
    input  logic              byte_wr_en_n_i,
    input  logic [3:0]        lane_n_i,
    input  logic              linear_i,
    input  logic              sleep_i,
    input  logic              out_en_n_i,
    input  logic [31:0]       data_i,
    output logic [31:0]       data_o,
    output logic              data_oe_o
);
    logic              awake;
    acc_t              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd_valid;

    burst_sram_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .sleep_i (sleep_i),
        .awake_o (awake)
    );

    burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .awake_i         (awake),
        .addr_i          (addr_i),
        .cs1_n_i         (cs1_n_i),
        .cs2_i           (cs2_i),
        .cs3_n_i         (cs3_n_i),
        .proc_strobe_n_i (proc_strobe_n_i),
        .ctrl_strobe_n_i (ctrl_strobe_n_i),
        .advance_n_i     (advance_n_i),
        .global_wr_n_i   (global_wr_n_i),
        .byte_wr_en_n_i  (byte_wr_en_n_i),
        .lane_n_i        (lane_n_i),
        .linear_i        (linear_i),
        .data_i          (data_i),
        .acc_o           (acc),
        .acc_addr_o      (acc_addr)
    );

    burst_sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .acc_i      (acc),
        .acc_addr_i (acc_addr),
        .rd_data_o  (data_o),
        .rd_valid_o (rd_valid)
    );

    assign data_oe_o = rd_valid && !out_en_n_i;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic clk,
    input logic rst,
    input logic cs1_n_i,
    input logic cs2_i,
    input logic cs3_n_i,
    input logic proc_strobe_n_i,
    input logic ctrl_strobe_n_i,
    input logic sleep_i,
    input logic out_en_n_i,
    input logic data_oe_o,
    input logic awake,
    input logic acc_valid,
    input logic acc_write
);
    logic sel, strobe;
    assign sel    = !cs1_n_i && cs2_i && !cs3_n_i;
    assign strobe = (!proc_strobe_n_i && !cs1_n_i) || !ctrl_strobe_n_i;

    p_deselect_r1: assert property (@(posedge clk) disable iff (rst)
        (awake && strobe && !sel) |=> ##1 !data_oe_o);

    p_proc_read_r2: assert property (@(posedge clk) disable iff (rst)
        (awake && !proc_strobe_n_i && !cs1_n_i) |=> !acc_write);

    p_read_latency_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(acc_valid && !acc_write) && !out_en_n_i) |-> data_oe_o);

    p_oe_gate_r6: assert property (@(posedge clk) disable iff (rst)
        out_en_n_i |-> !data_oe_o);

    p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ##1 !data_oe_o);

    p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!data_oe_o && !acc_valid));

endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cs1_n_i         (cs1_n_i),
    .cs2_i           (cs2_i),
    .cs3_n_i         (cs3_n_i),
    .proc_strobe_n_i (proc_strobe_n_i),
    .ctrl_strobe_n_i (ctrl_strobe_n_i),
    .sleep_i         (sleep_i),
    .out_en_n_i      (out_en_n_i),
    .data_oe_o       (data_oe_o),
    .awake           (awake),
    .acc_valid       (acc.valid),
    .acc_write       (acc.write)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
    localparam int PERIOD = 10;
    localparam int NV     = 26;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr_i = '0;
    logic        cs1_n_i = 1'b0, cs2_i = 1'b1, cs3_n_i = 1'b0;
    logic        proc_strobe_n_i = 1'b1, ctrl_strobe_n_i = 1'b1, advance_n_i = 1'b1;
    logic        global_wr_n_i = 1'b1, byte_wr_en_n_i = 1'b1;
    logic [3:0]  lane_n_i = 4'hF;
    logic        linear_i = 1'b1, sleep_i = 1'b0, out_en_n_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [31:0] data_o;
    logic        data_oe_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    burst_sram u_dut (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .cs1_n_i(cs1_n_i), .cs2_i(cs2_i), .cs3_n_i(cs3_n_i),
        .proc_strobe_n_i(proc_strobe_n_i), .ctrl_strobe_n_i(ctrl_strobe_n_i),
        .advance_n_i(advance_n_i), .global_wr_n_i(global_wr_n_i),
        .byte_wr_en_n_i(byte_wr_en_n_i), .lane_n_i(lane_n_i), .linear_i(linear_i),
        .sleep_i(sleep_i), .out_en_n_i(out_en_n_i), .data_i(data_i),
        .data_o(data_o), .data_oe_o(data_oe_o)
    );

    // sel = {cs1_n, cs2, cs3_n}; 3'b010 selects.
    typedef struct packed {
        logic [7:0]  addr;
        logic [2:0]  sel;
        logic        ps_n, cs_n, adv_n, gw_n, bwe_n;
        logic [3:0]  lane_n;
        logic        lin;
        logic [31:0] din;
        logic        eoe;
        logic [31:0] edat;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mk(input logic [7:0] a, input logic [2:0] s,
                                input logic p, input logic c, input logic v,
                                input logic g, input logic b, input logic [3:0] l,
                                input logic ln, input logic [31:0] d,
                                input logic eo, input logic [31:0] ed, input logic [3:0] r);
        vec_t t;
        t.addr = a; t.sel = s; t.ps_n = p; t.cs_n = c; t.adv_n = v;
        t.gw_n = g; t.bwe_n = b; t.lane_n = l; t.lin = ln; t.din = d;
        t.eoe = eo; t.edat = ed; t.req = r;
        return t;
    endfunction

    // Expected output columns describe the access of the previous row.
    localparam vec_t VEC [NV] = '{
        mk(8'h10, 3'b010, 1, 0, 1, 0, 1, 4'hF, 1, 32'hA0A00001, 0, 32'h0, 4'd11),        // R11 start write 0x10
        mk(8'h00, 3'b010, 1, 1, 0, 0, 1, 4'hF, 1, 32'hA0A00002, 0, 32'h0, 4'd3),         // R3 write -> 0x11
        mk(8'h00, 3'b010, 1, 1, 0, 0, 1, 4'hF, 1, 32'hA0A00003, 0, 32'h0, 4'd3),         // 0x12
        mk(8'h00, 3'b010, 1, 1, 0, 0, 1, 4'hF, 1, 32'hA0A00004, 0, 32'h0, 4'd3),         // 0x13
        mk(8'h00, 3'b110, 1, 0, 1, 1, 1, 4'hF, 1, 32'h0, 0, 32'h0, 4'd1),                // R1 deselect via cs1
        mk(8'h12, 3'b010, 0, 1, 1, 1, 1, 4'hF, 1, 32'h0, 0, 32'h0, 4'd1),                // read 0x12
        mk(8'h00, 3'b010, 1, 1, 0, 1, 1, 4'hF, 1, 32'h0, 1, 32'hA0A00003, 4'd5),         // R5 -> 0x13
        mk(8'h00, 3'b010, 1, 1, 0, 1, 1, 4'hF, 1, 32'h0, 1, 32'hA0A00004, 4'd7),         // R7 wrap -> 0x10
        mk(8'h00, 3'b010, 1, 1, 0, 1, 1, 4'hF, 1, 32'h0, 1, 32'hA0A00001, 4'd7),         // -> 0x11
        mk(8'h00, 3'b010, 1, 1, 1, 1, 1, 4'hF, 1, 32'h0, 1, 32'hA0A00002, 4'd7),         // R8 hold 0x11
        mk(8'h00, 3'b010, 1, 1, 1, 1, 1, 4'hF, 1, 32'h0, 1, 32'hA0A00002, 4'd8),         // R8 hold 0x11
        mk(8'h11, 3'b010, 0, 1, 1, 1, 1, 4'hF, 0, 32'h0, 1, 32'hA0A00002, 4'd8),         // interleaved from 0x11
        mk(8'h00, 3'b010, 1, 1, 0, 1, 1, 4'hF, 0, 32'h0, 1, 32'hA0A00002, 4'd7),         // -> 0x10
        mk(8'h00, 3'b010, 1, 1, 0, 1, 1, 4'hF, 0, 32'h0, 1, 32'hA0A00001, 4'd7),         // R7 -> 0x13
        mk(8'h00, 3'b010, 1, 1, 0, 1, 1, 4'hF, 0, 32'h0, 1, 32'hA0A00004, 4'd7),         // -> 0x12
        mk(8'h20, 3'b010, 1, 0, 1, 0, 1, 4'hF, 1, 32'hFFFFFFFF, 1, 32'hA0A00003, 4'd7),  // R4 global write 0x20
        mk(8'h00, 3'b010, 1, 1, 1, 1, 0, 4'b1010, 1, 32'h11223344, 0, 32'h0, 4'd4),     // R4 lanes 0,2
        mk(8'h00, 3'b010, 1, 1, 1, 1, 1, 4'b0000, 1, 32'h0, 0, 32'h0, 4'd4),            // R4 no bwe: read
        mk(8'h20, 3'b010, 0, 1, 1, 0, 1, 4'hF, 1, 32'h0, 1, 32'hFF22FF44, 4'd4),        // R2 ps with gw low
        mk(8'h00, 3'b010, 1, 1, 1, 1, 0, 4'b0111, 1, 32'hAB000000, 1, 32'hFF22FF44, 4'd2), // R2 then lane 3
        mk(8'h30, 3'b110, 0, 1, 1, 1, 1, 4'hF, 1, 32'h0, 0, 32'h0, 4'd10),               // R10 ps ignored
        mk(8'h00, 3'b010, 1, 1, 1, 1, 1, 4'hF, 1, 32'h0, 1, 32'hAB22FF44, 4'd10),        // R10 burst kept 0x20
        mk(8'h11, 3'b010, 1, 0, 1, 1, 1, 4'hF, 1, 32'h0, 1, 32'hAB22FF44, 4'd2),         // R3 ctrl read
        mk(8'h00, 3'b011, 1, 0, 1, 1, 1, 4'hF, 1, 32'h0, 1, 32'hA0A00002, 4'd3),         // R1 deselect via cs3
        mk(8'h00, 3'b010, 1, 1, 1, 1, 1, 4'hF, 1, 32'h0, 0, 32'h0, 4'd1),                // R1 off
        mk(8'h00, 3'b010, 1, 1, 1, 1, 1, 4'hF, 1, 32'h0, 0, 32'h0, 4'd1)                 // R1 stays off
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        addr_i = '0; {cs1_n_i, cs2_i, cs3_n_i} = 3'b010;
        proc_strobe_n_i = 1; ctrl_strobe_n_i = 1; advance_n_i = 1;
        global_wr_n_i = 1; byte_wr_en_n_i = 1; lane_n_i = 4'hF; data_i = '0;
    endtask

    task automatic chk_oe(input string req, input logic exp);
        checks++;
        if (data_oe_o !== exp) begin
            fails++;
            $display("FAIL %s data_oe_o actual=%b expected=%b", req, data_oe_o, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [31:0] exp);
        checks++;
        if (data_oe_o !== 1'b1 || data_o !== exp) begin
            fails++;
            $display("FAIL %s data_oe_o=%b data_o actual=%h expected=%h",
                     req, data_oe_o, data_o, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle();
        repeat (3) tick();
        rst = 0;
        #1;
        chk_oe("R11", 1'b0);

        for (int i = 0; i < NV; i++) begin
            addr_i = VEC[i].addr;
            {cs1_n_i, cs2_i, cs3_n_i} = VEC[i].sel;
            proc_strobe_n_i = VEC[i].ps_n; ctrl_strobe_n_i = VEC[i].cs_n;
            advance_n_i = VEC[i].adv_n; global_wr_n_i = VEC[i].gw_n;
            byte_wr_en_n_i = VEC[i].bwe_n; lane_n_i = VEC[i].lane_n;
            linear_i = VEC[i].lin; data_i = VEC[i].din;
            tick();
            checks++;
            if (data_oe_o !== VEC[i].eoe || (VEC[i].eoe && data_o !== VEC[i].edat)) begin
                fails++;
                $display("FAIL R%0d row %0d oe=%b data=%h expected oe=%b data=%h",
                         VEC[i].req, i, data_oe_o, data_o, VEC[i].eoe, VEC[i].edat);
            end
        end

        // R6: unclocked output enable
        idle(); linear_i = 1; proc_strobe_n_i = 0; addr_i = 8'h12;
        tick();
        idle();
        tick();
        chk_rd("R6", 32'hA0A00003);
        out_en_n_i = 1; #1;
        chk_oe("R6", 1'b0);
        checks++;
        if (data_o !== 32'hA0A00003) begin
            fails++;
            $display("FAIL R6 data_o actual=%h expected=%h", data_o, 32'hA0A00003);
        end
        out_en_n_i = 0; #1;
        chk_oe("R6", 1'b1);

        // R9: sleep and three-edge wake-up window
        idle(); ctrl_strobe_n_i = 0; addr_i = 8'h21; global_wr_n_i = 0; data_i = 32'h00000021;
        tick();
        idle(); sleep_i = 1; ctrl_strobe_n_i = 0; addr_i = 8'h20; global_wr_n_i = 0;
        tick();
        tick();
        chk_oe("R9", 1'b0);
        idle(); sleep_i = 0;
        tick();
        tick();
        chk_oe("R9", 1'b0);
        ctrl_strobe_n_i = 0; addr_i = 8'h21; global_wr_n_i = 0; data_i = 32'h12345678;
        tick();
        ctrl_strobe_n_i = 0; addr_i = 8'h22; global_wr_n_i = 0; data_i = 32'hCAFEF00D;
        tick();
        idle(); proc_strobe_n_i = 0; addr_i = 8'h21;
        tick();
        idle(); proc_strobe_n_i = 0; addr_i = 8'h22;
        tick();
        chk_rd("R9", 32'h00000021);
        idle(); proc_strobe_n_i = 0; addr_i = 8'h20;
        tick();
        chk_rd("R9", 32'hCAFEF00D);
        idle();
        tick();
        chk_rd("R9", 32'hAB22FF44);

        summary();
    end

endmodule